// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block decides, each cycle, whether the instruction sitting in decode may leave for execution in a pipeline with four execution paths. The integer path has a single execute stage. The floating-point adder is pipelined in several stages and the multiplier is pipelined in more stages. The divider is not pipelined and stays occupied for many cycles. The block receives the class of the decoding instruction, its destination and its two sources, and whether the shared register write port will be free. It also receives the occupancy and destination of every adder and multiplier stage and of the divider. From these it raises either `issue` or `stall`. A stall means the decode register holds its contents and a bubble goes downstream.

Three checks gate issue: a busy divider (structural), a source still being produced deeper in a unit (read-after-write), and a destination already claimed by an in-flight unit (write-after-write). For each source the block also drives a bypass select. The select picks among the integer result register, the three unit result registers at the memory boundary and the final write-back register. When several of these match, the youngest producer wins. The divider's occupancy is timed inside the block by a counter that is armed when a divide issues.

Registers are named by a tag whose top bit chooses the file. Dependences between the integer and floating-point files therefore arise only where an instruction really names the other file, as loads, stores and moves do.

Top module: `fpil_issue_gate`

## Requirements
- R1: With `dec_vld` high, exactly one of `issue` and `stall` is high, and `issue` is high only when no hazard exists. With `dec_vld` low, both are low.
- R2: A register tag is 6 bits: bit 5 selects the file (1 = floating point, 0 = integer) and bits 4:0 the index. Tags in different files never match, whatever their index.
- R3: Class code 3 is the divider. After a divide issues, a divide presented on each of the next 24 cycles stalls, and it issues on the 25th cycle. The divider is free out of reset.
- R4: Classes 0 (integer), 1 (adder) and 2 (multiplier) never stall for a structural reason. They can issue on consecutive cycles, including while the divider is busy.
- R5: When `dec_wr` is high and `wb_free` is low, the instruction stalls. When `dec_wr` is low, `wb_free` has no effect.
- R6: A used source whose tag equals the destination of a valid adder stage, a valid multiplier stage or a valid in-flight divide stalls the instruction. A source with its use flag low never stalls.
- R7: When `dec_wr` is high and `dec_dst` equals the destination of a valid adder stage, multiplier stage or in-flight divide, the instruction stalls. With `dec_wr` low, no such stall occurs.
- R8: The select of a used source is 1 for the integer result register, 2 for the adder result register, 3 for the multiplier result register, 4 for the divider result register and 5 for write-back, taken from bypass slot 0 to 4 in that order. A slot counts only when its valid bit is set and its tag equals the source. The select is 0 when no slot matches.
- R9: When several bypass slots match one source, the lowest select code is driven, so write-back has the lowest priority.
- R10: The select of a source whose use flag is low is 0.
- R11: A divide that is stalled does not occupy the divider. When its stall clears, it issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_vld | input | 1 | Decode holds an instruction |
| dec_cls | input | 2 | Unit class: 0 integer, 1 adder, 2 multiplier, 3 divider |
| dec_wr | input | 1 | Instruction writes a register |
| dec_dst | input | 6 | Destination tag |
| s1_use | input | 1 | First source is read |
| s1_tag | input | 6 | First source tag |
| s2_use | input | 1 | Second source is read |
| s2_tag | input | 6 | Second source tag |
| wb_free | input | 1 | Write port free when this instruction writes back |
| add_vld | input | 4 | Adder stage occupied, one bit per stage |
| add_dst | input | 24 | Adder stage destinations, 6 bits per stage |
| mul_vld | input | 7 | Multiplier stage occupied |
| mul_dst | input | 42 | Multiplier stage destinations |
| div_vld | input | 1 | A divide is in flight |
| div_dst | input | 6 | Destination of the in-flight divide |
| fw_vld | input | 5 | Bypass slot valid: 0 integer, 1 adder, 2 multiplier, 3 divider, 4 write-back |
| fw_dst | input | 30 | Bypass slot tags, 6 bits per slot |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Decode holds; bubble downstream |
| s1_sel | output | 3 | Bypass select for the first source |
| s2_sel | output | 3 | Bypass select for the second source |

## Verification
The assertions assume that the surrounding pipeline presents stage occupancy consistent with the issue decisions. They also assume that a divide result appears in the bypass slots only once the unit has finished. Above all, they take `issue` as the only event that arms the divider. The stimulus respects this by driving the stage and bypass inputs as static, independent patterns per scenario. It leaves `div_vld` low while it times the divider's occupancy, so any structural stall seen there comes from the internal counter alone.

// File: rtl/fpil_pkg.sv
package fpil_pkg;
  localparam int IDX_W = 5;
  localparam int TAG_W = IDX_W + 1;
  localparam int NFWD  = 5;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } ucls_e;

  // Tag comparison gated by a valid bit; the file bit is part of the tag.
  function automatic logic tag_hit(input logic [TAG_W-1:0] a,
                                   input logic [TAG_W-1:0] b,
                                   input logic v);
    return v && (a == b);
  endfunction

  // Lowest slot index wins; code = slot + 1, 0 means register file.
  function automatic logic [SEL_W-1:0] pick_fwd(input logic [NFWD-1:0] hits);
    logic [SEL_W-1:0] s;
    s = '0;
    for (int i = NFWD - 1; i >= 0; i--) begin
      if (hits[i]) s = SEL_W'(i + 1);
    end
    return s;
  endfunction
endpackage

// File: rtl/fpil_tag_cam.sv
module fpil_tag_cam import fpil_pkg::*; #(
  parameter int N = 4
) (
  input  logic [TAG_W-1:0]   q,
  input  logic               q_en,
  input  logic [N-1:0]       vld,
  input  logic [N*TAG_W-1:0] dst,
  output logic               hit
);
  logic [N-1:0] hits;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hits[i] = tag_hit(q, dst[i*TAG_W +: TAG_W], vld[i] & q_en);
  end

  assign hit = |hits;
endmodule

// File: rtl/fpil_div_track.sv
module fpil_div_track #(
  parameter int DIV_II = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(DIV_II) + 1;
  localparam logic [CW-1:0] LOAD = CW'(DIV_II - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fpil_fwd_pick.sv
module fpil_fwd_pick import fpil_pkg::*; (
  input  logic [TAG_W-1:0]      src,
  input  logic                  use_i,
  input  logic [NFWD-1:0]       fw_vld,
  input  logic [NFWD*TAG_W-1:0] fw_dst,
  output logic [SEL_W-1:0]      sel
);
  logic [NFWD-1:0] hits;

  for (genvar i = 0; i < NFWD; i++) begin : g_slot
    assign hits[i] = tag_hit(src, fw_dst[i*TAG_W +: TAG_W], fw_vld[i] & use_i);
  end

  assign sel = pick_fwd(hits);
endmodule

// File: rtl/fpil_issue_gate.sv
module fpil_issue_gate import fpil_pkg::*; #(
  parameter int ADD_STG = 4,
  parameter int MUL_STG = 7,
  parameter int DIV_II  = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_vld,
  input  logic [1:0]               dec_cls,
  input  logic                     dec_wr,
  input  logic [TAG_W-1:0]         dec_dst,
  input  logic                     s1_use,
  input  logic [TAG_W-1:0]         s1_tag,
  input  logic                     s2_use,
  input  logic [TAG_W-1:0]         s2_tag,
  input  logic                     wb_free,
  input  logic [ADD_STG-1:0]       add_vld,
  input  logic [ADD_STG*TAG_W-1:0] add_dst,
  input  logic [MUL_STG-1:0]       mul_vld,
  input  logic [MUL_STG*TAG_W-1:0] mul_dst,
  input  logic                     div_vld,
  input  logic [TAG_W-1:0]         div_dst,
  input  logic [NFWD-1:0]          fw_vld,
  input  logic [NFWD*TAG_W-1:0]    fw_dst,
  output logic                     issue,
  output logic                     stall,
  output logic [SEL_W-1:0]         s1_sel,
  output logic [SEL_W-1:0]         s2_sel
);
  localparam int NQ = 3;  // queries: source 1, source 2, destination

  ucls_e cls;
  assign cls = ucls_e'(dec_cls);

  logic [NQ-1:0][TAG_W-1:0] q_tag;
  logic [NQ-1:0]            q_en;
  logic [NQ-1:0]            add_hit, mul_hit, div_hit, fly_hit;

  assign q_tag = {dec_dst, s2_tag, s1_tag};
  assign q_en  = {dec_wr, s2_use, s1_use};

  for (genvar g = 0; g < NQ; g++) begin : g_q
    fpil_tag_cam #(.N(ADD_STG)) u_add (
      .q(q_tag[g]), .q_en(q_en[g]), .vld(add_vld), .dst(add_dst), .hit(add_hit[g]));
    fpil_tag_cam #(.N(MUL_STG)) u_mul (
      .q(q_tag[g]), .q_en(q_en[g]), .vld(mul_vld), .dst(mul_dst), .hit(mul_hit[g]));
    assign div_hit[g] = tag_hit(q_tag[g], div_dst, div_vld & q_en[g]);
    assign fly_hit[g] = add_hit[g] | mul_hit[g] | div_hit[g];
  end

  // Named hazard events (observed by the checker)
  logic div_busy, div_start;
  logic haz_struct, haz_port, haz_raw, haz_waw, haz_any;

  assign haz_struct = (cls == CLS_DIV) & div_busy;
  assign haz_port   = dec_wr & ~wb_free;
  assign haz_raw    = fly_hit[0] | fly_hit[1];
  assign haz_waw    = fly_hit[2];
  assign haz_any    = haz_struct | haz_port | haz_raw | haz_waw;

  assign issue     = dec_vld & ~haz_any;
  assign stall     = dec_vld &  haz_any;
  assign div_start = issue & (cls == CLS_DIV);

  fpil_div_track #(.DIV_II(DIV_II)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .busy(div_busy));

  logic [1:0][TAG_W-1:0] src_tag;
  logic [1:0]            src_use;
  logic [1:0][SEL_W-1:0] src_sel;

  assign src_tag = {s2_tag, s1_tag};
  assign src_use = {s2_use, s1_use};

  for (genvar s = 0; s < 2; s++) begin : g_src
    fpil_fwd_pick u_pick (
      .src(src_tag[s]), .use_i(src_use[s]), .fw_vld(fw_vld), .fw_dst(fw_dst),
      .sel(src_sel[s]));
  end

  assign s1_sel = src_sel[0];
  assign s2_sel = src_sel[1];
endmodule

// File: rtl/fpil_issue_gate_chk.sv
module fpil_issue_gate_chk import fpil_pkg::*; #(
  parameter int ADD_STG = 4,
  parameter int MUL_STG = 7,
  parameter int DIV_II  = 25
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_vld,
  input logic [1:0]               dec_cls,
  input logic                     dec_wr,
  input logic [TAG_W-1:0]         dec_dst,
  input logic                     s1_use,
  input logic [TAG_W-1:0]         s1_tag,
  input logic                     wb_free,
  input logic [ADD_STG-1:0]       add_vld,
  input logic [ADD_STG*TAG_W-1:0] add_dst,
  input logic [MUL_STG-1:0]       mul_vld,
  input logic [MUL_STG*TAG_W-1:0] mul_dst,
  input logic [NFWD-1:0]          fw_vld,
  input logic [NFWD*TAG_W-1:0]    fw_dst,
  input logic                     issue,
  input logic                     stall,
  input logic [SEL_W-1:0]         s1_sel,
  input logic                     div_busy
);
  localparam int GW = $clog2(DIV_II) + 2;

  logic          div_iss;
  logic          seen_div;
  logic [GW-1:0] gap;

  assign div_iss = issue && (dec_cls == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_div <= 1'b0;
      gap      <= '0;
    end else if (div_iss) begin
      seen_div <= 1'b1;
      gap      <= GW'(1);
    end else if (gap < GW'(DIV_II)) begin
      gap <= gap + 1'b1;
    end
  end

  logic waw_pres, raw1_pres;
  always_comb begin
    waw_pres  = 1'b0;
    raw1_pres = 1'b0;
    for (int i = 0; i < ADD_STG; i++) begin
      if (add_vld[i] && add_dst[i*TAG_W +: TAG_W] == dec_dst) waw_pres  = 1'b1;
      if (add_vld[i] && add_dst[i*TAG_W +: TAG_W] == s1_tag)  raw1_pres = 1'b1;
    end
    for (int i = 0; i < MUL_STG; i++) begin
      if (mul_vld[i] && mul_dst[i*TAG_W +: TAG_W] == dec_dst) waw_pres  = 1'b1;
      if (mul_vld[i] && mul_dst[i*TAG_W +: TAG_W] == s1_tag)  raw1_pres = 1'b1;
    end
  end

  p_one_of_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> (issue ^ stall));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> (!issue && !stall));

  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_iss && seen_div) |-> (gap >= GW'(DIV_II)));

  p_div_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    div_iss |=> div_busy);

  p_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_wr) |-> wb_free);

  p_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && s1_use) |-> !raw1_pres);

  p_waw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_wr) |-> !waw_pres);

  p_sel_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_sel != '0) |-> (s1_sel <= SEL_W'(NFWD) && fw_vld[s1_sel - 1'b1]
                        && fw_dst[(s1_sel - 1'b1)*TAG_W +: TAG_W] == s1_tag));

  p_sel_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_use |-> (s1_sel == '0));
endmodule

bind fpil_issue_gate fpil_issue_gate_chk #(
  .ADD_STG(ADD_STG), .MUL_STG(MUL_STG), .DIV_II(DIV_II)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_cls(dec_cls), .dec_wr(dec_wr),
  .dec_dst(dec_dst), .s1_use(s1_use), .s1_tag(s1_tag), .wb_free(wb_free),
  .add_vld(add_vld), .add_dst(add_dst), .mul_vld(mul_vld), .mul_dst(mul_dst),
  .fw_vld(fw_vld), .fw_dst(fw_dst), .issue(issue), .stall(stall),
  .s1_sel(s1_sel), .div_busy(div_busy)
);

// File: tb/sim_fpil_issue_gate.sv
module sim_fpil_issue_gate;
  localparam int CLK_P = 10;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_vld, dec_wr, s1_use, s2_use, wb_free, div_vld;
  logic [1:0] dec_cls;
  logic [TW-1:0] dec_dst, s1_tag, s2_tag, div_dst;
  logic [3:0] add_vld;
  logic [4*TW-1:0] add_dst;
  logic [6:0] mul_vld;
  logic [7*TW-1:0] mul_dst;
  logic [4:0] fw_vld;
  logic [5*TW-1:0] fw_dst;
  logic issue, stall;
  logic [2:0] s1_sel, s2_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  fpil_issue_gate u0 (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_cls(dec_cls), .dec_wr(dec_wr),
    .dec_dst(dec_dst), .s1_use(s1_use), .s1_tag(s1_tag), .s2_use(s2_use),
    .s2_tag(s2_tag), .wb_free(wb_free), .add_vld(add_vld), .add_dst(add_dst),
    .mul_vld(mul_vld), .mul_dst(mul_dst), .div_vld(div_vld), .div_dst(div_dst),
    .fw_vld(fw_vld), .fw_dst(fw_dst), .issue(issue), .stall(stall),
    .s1_sel(s1_sel), .s2_sel(s2_sel));

  function automatic logic [TW-1:0] fp(input int i);
    return {1'b1, 5'(i)};
  endfunction
  function automatic logic [TW-1:0] ir(input int i);
    return {1'b0, 5'(i)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_vld = 0; dec_cls = 0; dec_wr = 0; dec_dst = '0;
    s1_use = 0; s1_tag = '0; s2_use = 0; s2_tag = '0; wb_free = 1;
    add_vld = '0; add_dst = '0; mul_vld = '0; mul_dst = '0;
    div_vld = 0; div_dst = '0; fw_vld = '0; fw_dst = '0;
  endtask

  task automatic instr(input int cls, input logic [TW-1:0] d,
                       input logic [TW-1:0] a, input logic [TW-1:0] b);
    dec_vld = 1; dec_cls = 2'(cls); dec_wr = 1; dec_dst = d;
    s1_use = 1; s1_tag = a; s2_use = 1; s2_tag = b;
  endtask

  // settle point: half a cycle away from the rising edge
  task automatic step();
    @(negedge clk);
  endtask
  task automatic look();
    #1;
  endtask

  task automatic t_reset();
    step(); idle(); look();
    chk("R1 idle issue", issue, 0);
    chk("R1 idle stall", stall, 0);
    chk("R10 idle sel", s1_sel, 0);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 3; k++) begin
      step(); idle(); instr(k, fp(10 + k), fp(1), fp(2)); look();
      chk("R4 pipelined class issues", issue, 1);
      chk("R1 no stall", stall, 0);
    end
  endtask

  task automatic t_raw();
    step(); idle(); instr(1, fp(9), fp(5), fp(6));
    add_vld[1] = 1; add_dst[1*TW +: TW] = fp(5); look();
    chk("R6 raw on adder stage", stall, 1);
    add_vld[1] = 0; look();
    chk("R6 invalid stage ignored", issue, 1);
    s2_tag = fp(7); mul_vld[6] = 1; mul_dst[6*TW +: TW] = fp(7); look();
    chk("R6 raw on multiplier source 2", stall, 1);
    s2_use = 0; look();
    chk("R6 unused source ignored", issue, 1);
    div_vld = 1; div_dst = fp(5); look();
    chk("R6 raw on divide", stall, 1);
  endtask

  task automatic t_files();
    step(); idle(); instr(2, fp(20), fp(3), fp(4));
    mul_vld[2] = 1; mul_dst[2*TW +: TW] = ir(3);
    add_vld[0] = 1; add_dst[0 +: TW] = ir(20); look();
    chk("R2 cross-file tags do not match", issue, 1);
    mul_dst[2*TW +: TW] = fp(3); look();
    chk("R2 same-file tag matches", stall, 1);
  endtask

  task automatic t_waw();
    step(); idle(); instr(0, fp(12), ir(1), ir(2));
    mul_vld[6] = 1; mul_dst[6*TW +: TW] = fp(12); look();
    chk("R7 waw with multiplier", stall, 1);
    dec_wr = 0; look();
    chk("R7 no write no waw", issue, 1);
    dec_wr = 1; mul_vld = '0; add_vld[3] = 1; add_dst[3*TW +: TW] = fp(12); look();
    chk("R7 waw with adder", stall, 1);
  endtask

  task automatic t_port();
    step(); idle(); instr(1, fp(8), fp(1), fp(2)); wb_free = 0; look();
    chk("R5 port busy stalls", stall, 1);
    dec_wr = 0; look();
    chk("R5 port ignored without write", issue, 1);
  endtask

  task automatic t_fwd();
    step(); idle(); instr(1, fp(30), fp(4), fp(5));
    for (int sl = 0; sl < 5; sl++) begin
      fw_vld = '0; fw_vld[sl] = 1; fw_dst = '0; fw_dst[sl*TW +: TW] = fp(4); look();
      chk("R8 single slot select", s1_sel, sl + 1);
      chk("R8 other source untouched", s2_sel, 0);
    end
    fw_vld = '0; look();
    chk("R8 invalid slot gives regfile", s1_sel, 0);
    fw_vld = 5'b11010; fw_dst[1*TW +: TW] = fp(4); fw_dst[3*TW +: TW] = fp(4);
    fw_dst[4*TW +: TW] = fp(4); look();
    chk("R9 youngest match wins", s1_sel, 2);
    fw_vld = 5'b11000; look();
    chk("R9 write-back lowest", s1_sel, 4);
    fw_dst[4*TW +: TW] = fp(5); look();
    chk("R8 second source select", s2_sel, 5);
    s1_use = 0; look();
    chk("R10 unused source select", s1_sel, 0);
  endtask

  task automatic t_divider();
    step(); idle(); instr(3, fp(16), fp(1), fp(2)); wb_free = 0; look();
    chk("R11 stalled divide", stall, 1);
    for (int k = 0; k < 4; k++) begin
      step(); look();
      chk("R11 still held", stall, 1);
    end
    step(); wb_free = 1; look();
    chk("R11 divide issues once stall clears", issue, 1);
    step(); dec_dst = fp(17); look();
    chk("R3 second divide stalls", stall, 1);
    for (int k = 2; k <= 24; k++) begin
      step(); look();
      if (k == 12) begin
        instr(1, fp(18), fp(1), fp(2)); look();
        chk("R4 adder issues while divider busy", issue, 1);
        instr(3, fp(17), fp(1), fp(2)); look();
      end
      chk("R3 divide held during interval", stall, 1);
    end
    step(); look();
    chk("R3 divide issues on 25th cycle", issue, 1);
    step(); idle(); look();
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    t_reset();
    step(); rst_n = 1;
    t_reset();
    t_back_to_back();
    t_raw();
    t_files();
    t_waw();
    t_port();
    t_fwd();
    t_divider();
    step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule